// File: doc/BRIEF.md
# Dual-Channel Fast PWM Timer

This block is a 16-bit up-counter that generates two pulse-width modulated outputs. The counter climbs from zero to a programmable ceiling and then restarts from zero, so each cycle of the waveform lasts (ceiling + 1) counter steps. The counter steps on a tick that comes from one of three sources. It can be a fixed power-of-two division of the system clock, a synchronised edge of an external clock pin, or nothing at all, in which case the counter is halted.

Each channel compares the count against its own threshold and forms either a true or a complemented waveform. A channel can also let its pin fall back to an ordinary port value. Software programs the block through a simple write port. The ceiling and the thresholds are held in shadow registers. They move into the active copies only at the end of a waveform cycle, or at once while the counter is halted.

Top module: `pwm_fast_timer`

## Requirements
- R1: Write port, one register per address. Address 0 is control: bits 2:0 select the clock and bits 5+2n:4+2n hold the output mode of channel n. Address 1 is the ceiling. Address 2 is the threshold of channel 0 and address 3 the threshold of channel 1.
- R2: After reset the counter, ceiling and thresholds are zero, the clock is halted and both modes are 00, so each pin shows its port value.
- R3: The counter steps once per tick from 0 up to the ceiling and returns to 0 on the next tick. One waveform cycle therefore lasts prescale × (ceiling + 1) system cycles.
- R4: Mode 10 (true): the pin is high from the step where the count returns to zero until the step after the count equals the threshold. With a threshold below the ceiling, it is high for prescale × (threshold + 1) cycles of each waveform cycle.
- R5: Mode 11 (complemented): the pin is the inverse of the mode 10 waveform.
- R6: A threshold of 0 gives a pin that is high for exactly one counter step per waveform cycle in mode 10.
- R7: A threshold equal to or above the ceiling never matches. The pin stays constantly high in mode 10 and constantly low in mode 11.
- R8: Modes 00 and 01 disconnect the channel, and its pin follows the port value.
- R9: When a channel's output-enable input is low, its pin follows the port value whatever the mode.
- R10: Clock-select codes 001, 010, 011, 100 and 101 divide the system clock by 1, 8, 64, 256 and 1024.
- R11: Code 110 steps the counter on falling edges of the external clock and code 111 on rising edges. The external clock is first passed through a two-stage synchroniser. The counter advances at most once per system cycle.
- R12: Code 000 halts the counter at zero, copies the shadow ceiling and thresholds into the active registers at once, and holds each driven pin at its start-of-cycle level: high in mode 10, low in mode 11.
- R13: While the counter runs, a write to the ceiling or a threshold leaves the waveform cycle in progress unchanged and takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address |
| wrData | input | 16 | Register write data |
| extClk | input | 1 | External count clock, asynchronous |
| outEn | input | 2 | Per-channel pin output enable |
| portVal | input | 2 | Per-channel normal port value |
| pwmPin | output | 2 | Per-channel pin level |

## Verification
A register write lands in the shadow at the next clock edge. While the counter is halted, the active copy follows one edge later. While it runs, the active copy waits for the wrap edge. A divided tick changes the waveform register on the same edge that advances the counter, and the pin follows with no further delay. An external edge needs two synchroniser stages plus one history stage before it produces a tick. Because every one of these latencies is fixed, the bench does not predict absolute cycle numbers. It samples pins at falling clock edges and measures the high time and the full cycle length between pin transitions. For the buffering checks it issues the write a known number of cycles into a measured high phase, then expects the old values for that cycle and the new values for the one after.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

  localparam int CS_W       = 3;
  localparam int MODE_LSB   = 4;
  localparam int PS_LOG2MAX = 10;
  localparam int PS_W       = PS_LOG2MAX;

  localparam int ADDR_CTRL = 0;
  localparam int ADDR_TOP  = 1;
  localparam int ADDR_CMP0 = 2;

  typedef enum logic [CS_W-1:0] {
    CS_STOP     = 3'b000,
    CS_DIV1     = 3'b001,
    CS_DIV8     = 3'b010,
    CS_DIV64    = 3'b011,
    CS_DIV256   = 3'b100,
    CS_DIV1024  = 3'b101,
    CS_EXT_FALL = 3'b110,
    CS_EXT_RISE = 3'b111
  } clkSel_e;

  typedef enum logic [1:0] {
    OM_OFF    = 2'b00,
    OM_RSVD   = 2'b01,
    OM_NONINV = 2'b10,
    OM_INV    = 2'b11
  } outMode_e;

  typedef struct packed {
    logic tick;
    logic halted;
  } tmrStrobe_t;

  function automatic int divShift(clkSel_e sel);
    case (sel)
      CS_DIV8:    return 3;
      CS_DIV64:   return 6;
      CS_DIV256:  return 8;
      CS_DIV1024: return PS_LOG2MAX;
      default:    return 0;
    endcase
  endfunction

endpackage

// File: rtl/pwm_timer_ctrl.sv
module pwm_timer_ctrl
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 3
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           wrEn,
  input  logic [ADDR_W-1:0]              wrAddr,
  input  logic [CNT_W-1:0]               wrData,
  input  logic                           extClk,
  output tmrStrobe_t                     strb,
  output logic [CNT_W-1:0]               shTop,
  output logic [NUM_CH-1:0][CNT_W-1:0]   shCmp,
  output logic [NUM_CH-1:0][1:0]         chMode
);

  clkSel_e        clkSel;
  logic [PS_W-1:0] psCnt;
  logic [PS_W-1:0] psLim;
  logic            intDiv;
  logic            divTick;
  logic [2:0]      extSync;
  logic            extRise;
  logic            extFall;

  // control register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkSel <= CS_STOP;
      chMode <= '0;
    end else if (wrEn && wrAddr == ADDR_W'(ADDR_CTRL)) begin
      clkSel <= clkSel_e'(wrData[CS_W-1:0]);
      for (int ch = 0; ch < NUM_CH; ch++)
        chMode[ch] <= wrData[MODE_LSB+2*ch +: 2];
    end
  end

  // shadow ceiling and thresholds
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shTop <= '0;
      shCmp <= '0;
    end else if (wrEn) begin
      if (wrAddr == ADDR_W'(ADDR_TOP)) shTop <= wrData;
      for (int ch = 0; ch < NUM_CH; ch++)
        if (wrAddr == ADDR_W'(ADDR_CMP0 + ch)) shCmp[ch] <= wrData;
    end
  end

  // internal prescaler
  always_comb begin
    intDiv = (clkSel == CS_DIV1) || (clkSel == CS_DIV8) || (clkSel == CS_DIV64) ||
             (clkSel == CS_DIV256) || (clkSel == CS_DIV1024);
    psLim  = PS_W'((1 << divShift(clkSel)) - 1);
  end

  assign divTick = intDiv && (psCnt >= psLim);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  psCnt <= '0;
    else if (!intDiv || divTick) psCnt <= '0;
    else                        psCnt <= psCnt + 1'b1;
  end

  // external clock: two synchroniser stages plus one history stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) extSync <= '0;
    else       extSync <= {extSync[1:0], extClk};
  end

  assign extRise = extSync[1] & ~extSync[2];
  assign extFall = ~extSync[1] & extSync[2];

  always_comb begin
    strb.halted = (clkSel == CS_STOP);
    strb.tick   = divTick ||
                  (clkSel == CS_EXT_RISE && extRise) ||
                  (clkSel == CS_EXT_FALL && extFall);
  end

  // R10 R11
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick && clkSel != CS_DIV1 && clkSel != CS_STOP) |=>
      (!strb.tick || clkSel != $past(clkSel)));

  // R12
  halt_no_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clkSel == CS_STOP) |-> !strb.tick);

endmodule

// File: rtl/pwm_timer_core.sv
module pwm_timer_core
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  tmrStrobe_t                   strb,
  input  logic [CNT_W-1:0]             shTop,
  input  logic [NUM_CH-1:0][CNT_W-1:0] shCmp,
  input  logic [NUM_CH-1:0][1:0]       chMode,
  output logic [NUM_CH-1:0]            waveOut,
  output logic [NUM_CH-1:0]            drive
);

  logic [CNT_W-1:0]             cnt;
  logic [CNT_W-1:0]             actTop;
  logic [NUM_CH-1:0][CNT_W-1:0] actCmp;
  logic [NUM_CH-1:0]            phase;
  logic                         atTop;
  logic                         wrapNow;
  logic                         loadAct;

  assign atTop   = (cnt == actTop);
  assign wrapNow = strb.tick && atTop;
  assign loadAct = strb.halted || wrapNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cnt <= '0;
    else if (strb.halted) cnt <= '0;
    else if (strb.tick)   cnt <= atTop ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actTop <= '0;
      actCmp <= '0;
    end else if (loadAct) begin
      actTop <= shTop;
      actCmp <= shCmp;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= '0;
    else begin
      for (int ch = 0; ch < NUM_CH; ch++) begin
        if (strb.halted || wrapNow)
          phase[ch] <= 1'b1;
        else if (strb.tick && cnt == actCmp[ch] && actCmp[ch] != actTop)
          phase[ch] <= 1'b0;
      end
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gCh
    assign waveOut[ch] = (chMode[ch] == OM_INV) ? ~phase[ch] : phase[ch];
    assign drive[ch]   = chMode[ch][1];

    // R7
    match_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
      $fell(phase[ch]) |-> ($past(actCmp[ch]) != $past(actTop)));
  end

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= actTop);

  // R3
  wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick && cnt == actTop) |=> (cnt == '0));

  // R3
  step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick && cnt != actTop) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  // R13
  hold_top_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.halted && !(strb.tick && cnt == actTop)) |=> $stable(actTop));

  // R12
  halt_bottom_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.halted |=> (cnt == '0 && phase == '1));

endmodule

// File: rtl/pwm_fast_timer.sv
module pwm_fast_timer
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic              extClk,
  input  logic [NUM_CH-1:0] outEn,
  input  logic [NUM_CH-1:0] portVal,
  output logic [NUM_CH-1:0] pwmPin
);

  tmrStrobe_t                   strb;
  logic [CNT_W-1:0]             shTop;
  logic [NUM_CH-1:0][CNT_W-1:0] shCmp;
  logic [NUM_CH-1:0][1:0]       chMode;
  logic [NUM_CH-1:0]            waveOut;
  logic [NUM_CH-1:0]            drive;

  pwm_timer_ctrl #(.CNT_W(CNT_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .extClk(extClk), .strb(strb), .shTop(shTop), .shCmp(shCmp), .chMode(chMode)
  );

  pwm_timer_core #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) uCore (
    .clk(clk), .rstN(rstN), .strb(strb), .shTop(shTop), .shCmp(shCmp),
    .chMode(chMode), .waveOut(waveOut), .drive(drive)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gPin
    assign pwmPin[ch] = (drive[ch] && outEn[ch]) ? waveOut[ch] : portVal[ch];
  end

endmodule

// File: tb/sim_pwm_fast_timer.sv
module sim_pwm_fast_timer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        extClk = 1'b0;
  logic [1:0]  outEn = 2'b11;
  logic [1:0]  portVal = 2'b10;
  logic [1:0]  pwmPin;

  int errors = 0;
  int checks = 0;
  localparam int LIM = 60000;

  pwm_fast_timer u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .extClk(extClk), .outEn(outEn), .portVal(portVal), .pwmPin(pwmPin)
  );

  always #5 clk = ~clk;
  always #30 extClk = ~extClk;

  function automatic int psOf(int cs);
    case (cs)
      2: return 8;
      3: return 64;
      4: return 256;
      5: return 1024;
      6, 7: return 6;
      default: return 1;
    endcase
  endfunction

  function automatic int expHi(int ps, int top, int cmp, bit inv);
    int nh;
    nh = ps * (cmp + 1);
    return inv ? ps * (top + 1) - nh : nh;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int addr, int data);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 3'(addr); wrData = 16'(data);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic cfg(int cs, int top, int cmpA, int cmpB, int mA, int mB);
    wr(0, (mA << 4) | (mB << 6));
    wr(1, top);
    wr(2, cmpA);
    wr(3, cmpB);
    wr(0, cs | (mA << 4) | (mB << 6));
  endtask

  task automatic measure(int ch, bit doWr, int wa, int wd, output int hi, output int per);
    int guard;
    int lo;
    guard = 0; hi = 0; lo = 0;
    while (pwmPin[ch] == 1'b1 && guard < LIM) begin @(negedge clk); guard++; end
    while (pwmPin[ch] == 1'b0 && guard < LIM) begin @(negedge clk); guard++; end
    while (pwmPin[ch] == 1'b1 && guard < LIM) begin
      hi++;
      if (doWr && hi == 3) begin wrEn = 1'b1; wrAddr = 3'(wa); wrData = 16'(wd); end
      else wrEn = 1'b0;
      @(negedge clk); guard++;
    end
    wrEn = 1'b0;
    while (pwmPin[ch] == 1'b0 && guard < LIM) begin lo++; @(negedge clk); guard++; end
    per = hi + lo;
    if (guard >= LIM) begin hi = -1; per = -1; end
  endtask

  task automatic measCase(int ch, int cs, int top, int cmp, bit inv, string req);
    int ps;
    int per;
    int hi;
    int mp;
    int bad;
    bit lvl;
    ps = psOf(cs);
    per = ps * (top + 1);
    if (cmp >= top) begin
      lvl = !inv; bad = 0;
      for (int i = 0; i < 2 * per + 4; i++) begin
        @(negedge clk);
        if (pwmPin[ch] !== lvl) bad++;
      end
      check(bad == 0, {req, " R7 constant level"}, bad, 0);
    end else begin
      measure(ch, 1'b0, 0, 0, hi, mp);
      check(hi == expHi(ps, top, cmp, inv), {req, " high time"}, hi, expHi(ps, top, cmp, inv));
      check(mp == per, "R3 cycle length", mp, per);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R3 watchdog: actual=timeout expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int hi;
    int per;
    int bad;
    int unsigned r;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R2 reset: pins follow port, nothing counts
    bad = 0;
    for (int i = 0; i < 50; i++) begin @(negedge clk); if (pwmPin !== 2'b10) bad++; end
    check(bad == 0, "R2 reset pins follow port", int'(pwmPin), 2);

    // R12 halted with modes set: start-of-cycle levels
    wr(1, 20); wr(2, 5); wr(3, 5);
    wr(0, (2 << 4) | (3 << 6));
    bad = 0;
    for (int i = 0; i < 100; i++) begin @(negedge clk); if (pwmPin !== 2'b01) bad++; end
    check(bad == 0, "R12 halted levels", int'(pwmPin), 1);
    // R12 shadow loaded while halted; R1 map: start /1
    wr(0, 1 | (2 << 4) | (3 << 6));
    measCase(0, 1, 20, 5, 1'b0, "R12 R1 R4 ch0 after halt");
    measCase(1, 1, 20, 5, 1'b1, "R1 R5 ch1 inverted");

    // R10 prescaler settings
    cfg(1, 9, 3, 3, 2, 3);
    measCase(0, 1, 9, 3, 1'b0, "R10 div1");
    cfg(2, 9, 3, 3, 2, 3);
    measCase(0, 2, 9, 3, 1'b0, "R10 div8");
    measCase(1, 2, 9, 3, 1'b1, "R10 R5 div8 inv");
    cfg(3, 4, 2, 2, 2, 3);
    measCase(0, 3, 4, 2, 1'b0, "R10 div64");
    cfg(4, 3, 1, 1, 2, 3);
    measCase(0, 4, 3, 1, 1'b0, "R10 div256");
    cfg(5, 2, 0, 0, 2, 3);
    measCase(0, 5, 2, 0, 1'b0, "R10 R6 div1024 cmp0");

    // R6 threshold zero, R7 threshold at and above ceiling
    cfg(1, 7, 0, 7, 2, 2);
    measCase(0, 1, 7, 0, 1'b0, "R6 cmp zero");
    measCase(1, 1, 7, 7, 1'b0, "R7 cmp eq top noninv");
    cfg(1, 7, 7, 9, 3, 3);
    measCase(0, 1, 7, 7, 1'b1, "R7 cmp eq top inv");
    measCase(1, 1, 7, 9, 1'b1, "R7 cmp above top inv");

    // R11 external clock, both edges
    cfg(6, 4, 1, 3, 2, 3);
    measCase(0, 6, 4, 1, 1'b0, "R11 ext falling");
    measCase(1, 6, 4, 3, 1'b1, "R11 ext falling inv");
    cfg(7, 4, 1, 3, 2, 3);
    measCase(0, 7, 4, 1, 1'b0, "R11 ext rising");

    // R8 modes 00 and 01 disconnect
    cfg(1, 5, 2, 2, 1, 0);
    bad = 0;
    portVal = 2'b11;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (pwmPin !== 2'b11) bad++; end
    portVal = 2'b00;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (pwmPin !== 2'b00) bad++; end
    check(bad == 0, "R8 disconnected modes", bad, 0);

    // R9 output enable low
    cfg(1, 5, 2, 2, 2, 3);
    outEn = 2'b00; portVal = 2'b01;
    bad = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (pwmPin !== 2'b01) bad++; end
    check(bad == 0, "R9 enable low", bad, 0);
    outEn = 2'b11; portVal = 2'b00;

    // R13 buffered threshold
    cfg(1, 99, 49, 49, 2, 2);
    measure(0, 1'b1, 2, 9, hi, per);
    check(hi == 50, "R13 threshold cycle in progress", hi, 50);
    measure(0, 1'b0, 0, 0, hi, per);
    check(hi == 10, "R13 threshold next cycle", hi, 10);
    // R13 buffered ceiling
    measure(0, 1'b1, 1, 59, hi, per);
    check(per == 100, "R13 ceiling cycle in progress", per, 100);
    measure(0, 1'b0, 0, 0, hi, per);
    check(per == 60 && hi == 10, "R13 ceiling next cycle", per, 60);

    // random configurations
    void'($urandom(32'd2024));
    for (int k = 0; k < 8; k++) begin
      int cs;
      int top;
      int cmp;
      int ch;
      bit inv;
      r = $urandom; cs = 1 + int'(r % 3);
      r = $urandom; top = 1 + int'(r % 30);
      r = $urandom; cmp = int'(r % (top + 3));
      r = $urandom; inv = r[0];
      r = $urandom; ch = int'(r % 2);
      if (ch == 0) cfg(cs, top, cmp, 0, inv ? 3 : 2, 0);
      else         cfg(cs, top, 0, cmp, 0, inv ? 3 : 2);
      measCase(ch, cs, top, cmp, inv, "R4 R5 R10 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule